// File: doc/BRIEF.md
# One-Shot Cycle Interrupt Timer

This block is a down-counting interrupt timer that advances once per CPU cycle, on each cycle that the tick enable is high. Software stages a low byte through one write address. It then writes the high byte to a second address, and that write loads the full counter and arms it. When the count reaches zero, the timer raises an interrupt-pending flag and disarms itself. A new write of the high byte is the only way to arm it again.

Software polls the flag through a status address. A read there returns the flag in bit 0. Bits 7:1 of the read pass straight through from the open-bus value that the system supplies. The status read clears the flag, and so does a write to either counter address. The interrupt output follows the flag directly.

Top module: `otmr_timer`

## Requirements
- R1: After reset, irq_o is low, a status read returns bit 0 = 0, and the timer is disarmed: ticks raise no interrupt.
- R2: A write to LO_ADDR (default 16'h4020) stores wr_data_i as the staged low byte. The write does not arm the timer.
- R3: A write to HI_ADDR (default 16'h4021) loads the counter with {wr_data_i, staged low byte} and arms it. A load of N (N > 0) sets irq_o after the clock edge of the N-th tick: a load of 3 fires on the 3rd tick, and a load of 16'h0100 fires on the 256th tick.
- R4: Cycles with tick_i low do not advance the counter.
- R5: When the timer fires, it disarms itself. No further interrupt occurs, however many ticks follow, until HI_ADDR is written again.
- R6: While rd_en_i is high and rd_addr_i equals STAT_ADDR (default 16'h4030), rd_data_o is {open_bus_i[7:1], pending}. For any other read, rd_data_o equals open_bus_i.
- R7: A status read clears the pending flag at the clock edge that ends the read.
- R8: A write to LO_ADDR or HI_ADDR clears the pending flag.
- R9: If the counter reaches zero in the same cycle as a clearing access, the clearing access wins and pending stays low. The timer still disarms.
- R10: A write to HI_ADDR in a cycle with an active tick loads the counter without decrementing it.
- R11: While disarmed, ticks leave the counter unchanged and raise no interrupt.
- R12: A load of 0 wraps through 16'hFFFF and fires on the 65536th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 16 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 16 | Read address |
| open_bus_i | input | 8 | Value left on the data bus by the previous transfer |
| rd_data_o | output | 8 | Read data |
| tick_i | input | 1 | Count enable, one pulse per CPU cycle |
| irq_o | output | 1 | Interrupt request, high while pending |

## Verification
The bench uses the default 8-bit data width, which gives a 16-bit counter. With that counter, the full wrap from a zero load (65536 ticks) fits in one run, along with the 256-tick high-byte case. The random phase keeps loads below 64 so that firing happens often. This brings many collisions into reach: clearing accesses and reloads that land on the firing cycle, and ticks that land on the load cycle.

// File: rtl/otmr_pkg.sv
`timescale 1ns/1ps
package otmr_pkg;
  typedef struct packed {
    logic wr_lo;
    logic wr_hi;
    logic rd_stat;
  } otmr_acc_t;
endpackage

// File: rtl/otmr_decode.sv
`timescale 1ns/1ps
module otmr_decode
  import otmr_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] LO_ADDR   = 16'h4020,
  parameter logic [15:0] HI_ADDR   = 16'h4021,
  parameter logic [15:0] STAT_ADDR = 16'h4030
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output otmr_acc_t         acc_o
);
  localparam logic [ADDR_W-1:0] LoA = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HiA = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] StA = ADDR_W'(STAT_ADDR);

  always_comb begin
    acc_o.wr_lo   = wr_en_i && (wr_addr_i == LoA);
    acc_o.wr_hi   = wr_en_i && (wr_addr_i == HiA);
    acc_o.rd_stat = rd_en_i && (rd_addr_i == StA);
  end

  // R2
  wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_o.wr_lo, acc_o.wr_hi}));
endmodule

// File: rtl/otmr_counter.sv
`timescale 1ns/1ps
module otmr_counter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [CNT_W-1:0]  ld_val_i,
  input  logic              tick_i,
  output logic              fire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_dec;
  logic             en_q;
  logic             step;

  assign step    = tick_i && en_q && !ld_i;  // load wins over a tick
  assign cnt_dec = cnt_q - CNT_W'(1);
  assign fire_o  = step && (cnt_dec == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
      en_q  <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_dec;
      if (fire_o) en_q <= 1'b0;
    end
  end

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> en_q && (cnt_q == $past(ld_val_i)));
  // R5
  disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> $past(fire_o));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !(tick_i && en_q)) |=> $stable(cnt_q));
endmodule

// File: rtl/otmr_flag.sv
`timescale 1ns/1ps
module otmr_flag #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              rd_sel_i,
  input  logic [DATA_W-1:0] open_bus_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (clr_i)  pend_q <= 1'b0;  // clear beats set
    else if (set_i)  pend_q <= 1'b1;
  end

  always_comb begin
    rd_data_o = open_bus_i;
    if (rd_sel_i) rd_data_o[0] = pend_q;
  end

  assign pend_o = pend_q;

  // R7
  // R8
  // R9
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pend_q);
  // R3
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(set_i));
endmodule

// File: rtl/otmr_timer.sv
`timescale 1ns/1ps
module otmr_timer
  import otmr_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] LO_ADDR   = 16'h4020,
  parameter logic [15:0] HI_ADDR   = 16'h4021,
  parameter logic [15:0] STAT_ADDR = 16'h4030
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] open_bus_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tick_i,
  output logic              irq_o
);
  localparam int CntW = 2 * DATA_W;

  otmr_acc_t        acc;
  logic [DATA_W-1:0] low_q;
  logic              fire, pend;

  otmr_decode #(
    .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .rd_en_i, .rd_addr_i, .acc_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        low_q <= '0;
    else if (acc.wr_lo) low_q <= wr_data_i;
  end

  otmr_counter #(.DATA_W(DATA_W), .CNT_W(CntW)) u_cnt (
    .clk_i, .rst_ni,
    .ld_i    (acc.wr_hi),
    .ld_val_i({wr_data_i, low_q}),
    .tick_i,
    .fire_o  (fire)
  );

  otmr_flag #(.DATA_W(DATA_W)) u_flag (
    .clk_i, .rst_ni,
    .set_i     (fire),
    .clr_i     (acc.wr_lo || acc.wr_hi || acc.rd_stat),
    .rd_sel_i  (acc.rd_stat),
    .open_bus_i,
    .rd_data_o,
    .pend_o    (pend)
  );

  assign irq_o = pend;

  // R1
  irq_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(irq_o));
endmodule

// File: tb/otmr_timer_test.sv
`timescale 1ns/1ps
module otmr_timer_test;
  localparam logic [15:0] LO = 16'h4020, HI = 16'h4021, ST = 16'h4030;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, rd_en_i = 0, tick_i = 0;
  logic [15:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [7:0] wr_data_i = 0, open_bus_i = 0, rd_data_o;
  logic irq_o;

  int errors = 0, checks = 0;
  logic [7:0]  m_low = 0;
  logic [15:0] m_cnt = 0;
  logic        m_en = 0, m_pend = 0;

  otmr_timer uut (.*);

  always #2.5 clk_i = ~clk_i;

  function automatic logic [7:0] exp_rd(input logic re, input logic [15:0] ra,
                                        input logic [7:0] ob, input logic p);
    return (re && ra == ST) ? {ob[7:1], p} : ob;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check read, step model at posedge, check irq
  task automatic cyc(input logic we, input logic [15:0] wa, input logic [7:0] wd,
                     input logic re, input logic [15:0] ra, input logic [7:0] ob,
                     input logic tk, input string req);
    logic wlo, whi, clr, fire;
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    rd_en_i = re; rd_addr_i = ra; open_bus_i = ob; tick_i = tk;
    #1;
    if (re) chk({req, "/R6"}, {8'h0, rd_data_o}, {8'h0, exp_rd(re, ra, ob, m_pend)});
    wlo = we && wa == LO; whi = we && wa == HI;
    clr = wlo || whi || (re && ra == ST);
    fire = 0;
    if (whi) begin m_cnt = {wd, m_low}; m_en = 1; end
    else if (tk && m_en) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin m_en = 0; fire = 1; end
    end
    if (wlo) m_low = wd;
    if (clr) m_pend = 0; else if (fire) m_pend = 1;
    @(posedge clk_i); #1;
    chk(req, {15'h0, irq_o}, {15'h0, m_pend});
  endtask

  task automatic idle(input logic tk, input string req);
    cyc(0, 0, 0, 0, 0, 8'h5A, tk, req);
  endtask

  task automatic load(input logic [15:0] v, input string req);
    cyc(1, LO, v[7:0], 0, 0, 0, 0, req);
    cyc(1, HI, v[15:8], 0, 0, 0, 0, req);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk_i);
    rst_ni = 1;
    // R1 reset state
    #1 chk("R1", {15'h0, irq_o}, 0);
    cyc(0, 0, 0, 1, ST, 8'hFF, 0, "R1");
    for (int i = 0; i < 20; i++) idle(1, "R1");
    // R2 staging alone does not arm, R11 disarmed ticks quiet
    cyc(1, LO, 8'h02, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 10; i++) idle(1, "R11");
    // R3 load 3 fires on 3rd tick
    load(16'd3, "R3");
    for (int i = 0; i < 3; i++) idle(1, "R3");
    // R6 status read bits and R7 clear
    cyc(0, 0, 0, 1, ST, 8'hA4, 0, "R7");
    cyc(0, 0, 0, 1, ST, 8'hA5, 0, "R7");
    cyc(0, 0, 0, 1, 16'h4031, 8'h3C, 0, "R6");
    // R3 high byte, R4 gaps
    load(16'h0100, "R3");
    for (int i = 0; i < 300; i++) idle(i % 3 != 0, "R4");
    // R5 one-shot
    for (int i = 0; i < 400; i++) idle(1, "R5");
    // R8 write clears pending
    load(16'd2, "R8"); idle(1, "R8"); idle(1, "R8");
    cyc(1, LO, 8'h09, 0, 0, 0, 0, "R8");
    load(16'd1, "R8"); idle(1, "R8");
    cyc(1, HI, 8'h00, 0, 0, 0, 0, "R8");
    idle(1, "R8");
    // R9 clear in firing cycle
    load(16'd2, "R9"); idle(1, "R9");
    cyc(0, 0, 0, 1, ST, 8'h00, 1, "R9");
    for (int i = 0; i < 5; i++) idle(1, "R9");
    load(16'd2, "R9"); idle(1, "R9");
    cyc(1, LO, 8'h01, 0, 0, 0, 1, "R9");
    for (int i = 0; i < 5; i++) idle(1, "R9");
    // R10 load with tick
    cyc(1, LO, 8'h03, 0, 0, 0, 1, "R10");
    cyc(1, HI, 8'h00, 0, 0, 0, 1, "R10");
    for (int i = 0; i < 4; i++) idle(1, "R10");
    cyc(0, 0, 0, 1, ST, 8'h00, 0, "R10");
    // R12 zero load wraps
    load(16'h0000, "R12");
    for (int i = 0; i < 65537; i++) idle(1, "R12");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic tk = $urandom_range(0, 9) < 7;
      if (r < 2)       cyc(1, LO, 8'($urandom_range(1, 63)), 0, 0, 8'($urandom), tk, "R2");
      else if (r < 4)  cyc(1, HI, 8'h00, 0, 0, 8'($urandom), tk, "R3");
      else if (r < 9)  cyc(0, 0, 0, 1, ST, 8'($urandom), tk, "R7");
      else if (r < 11) cyc(0, 0, 0, 1, 16'($urandom), 8'($urandom), tk, "R6");
      else             cyc(0, 0, 0, 0, 0, 8'($urandom), tk, "R5");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule